// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Overrun Lockout

This block receives bytes over a two-wire clocked serial link: a serial clock and a serial data line. Each frame is eight data bits, least significant bit first, with no start or stop bits. Data is taken on each rising edge of the serial clock. Both lines come in through a synchronizer in the system clock domain, and the edges are detected there. Bits collect in an internal shift register. When a frame is complete, the byte moves to a data register that software can read, and the ready flag is set.

Software reads the data register and a status register, and clears flags by writing zeros. If a second frame completes before software has cleared the ready flag, the new byte is dropped and the overrun flag is set. Reception then stops. It starts again only when every status flag is clear and the receive enable is high. Two level interrupts, for receive-complete and error, are gated by one interrupt enable.

Top module: `sync_rx_channel`

## Requirements
- R1: After reset, the data register reads 0x00, every status bit reads 0 and both interrupt outputs are low.
- R2: Eight serial bits taken on rising serial-clock edges, the first bit landing in data bit 0, form a byte. If the ready flag (status bit 0) is clear, the byte is placed in the data register (address 0) and the ready flag is set.
- R3: If a frame completes while the ready flag is 1, the overrun flag (status bit 1) is set, the ready flag stays 1 and the data register keeps the earlier byte.
- R4: The receive interrupt equals ready AND interrupt enable. The error interrupt equals (overrun OR framing OR parity) AND interrupt enable. With the enable at 0, both outputs are low.
- R5: Reception halts after an overrun. Frames sent while any status flag is 1 are ignored entirely. Once every flag is clear, reception resumes with the next whole frame.
- R6: Writing 0 to a status bit at address 1 clears that flag only if the flag has been read as 1 at address 1 since it was last cleared. Writing 1 to a bit leaves that flag unchanged.
- R7: Reading the data register does not clear the ready flag.
- R8: Deasserting the receive enable discards a partly received frame. The next frame after re-enabling is assembled from its own eight bits only.
- R9: The framing flag (status bit 2) and the parity flag (status bit 3) always read 0 in this mode.
- R10: When the receive enable is turned off and on again while the ready flag is 1, no frame is accepted until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Interrupt enable for both interrupt outputs |
| ser_clk | input | 1 | Serial clock from the link |
| ser_dat | input | 1 | Serial data from the link |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read address: 0 data, 1 status |
| rd_data | output | 8 | Read data (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 1 status |
| wr_data | input | 8 | Write data; a 0 bit clears a flag that has been read as 1 |
| irq_rx | output | 1 | Receive-complete interrupt (level) |
| irq_err | output | 1 | Error interrupt (level) |

## Verification
The hardest state to reach is the halted receiver with the ready flag set and the overrun flag already cleared. Only a frame that arrives at that moment shows whether the lockout watches every flag or only the error flags. The stimulus causes an overrun and then clears only the overrun bit, using a read followed by a selective zero-write. It then sends a full frame and checks that the data register and the ready flag are unchanged. After that it clears the ready flag and checks that the next frame is received.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int ADDR_W = 1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b1;
    localparam int FLAG_N = 4;
    localparam int F_RDY = 0;
    localparam int F_OVR = 1;
    localparam int F_FER = 2;
    localparam int F_PER = 3;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic rise,
    output logic bit_val
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] dat;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sck = {s_q.sck[STAGES-1:0], ser_clk};
        s_d.dat = {s_q.dat[STAGES-2:0], ser_dat};
        rise    = s_q.sck[STAGES-1] & ~s_q.sck[STAGES];
        bit_val = s_q.dat[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              flags_any,
    input  logic              err_any,
    input  logic              rise,
    input  logic              bit_val,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              running;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        frame_byte = {bit_val, s_q.sh[DATA_W-1:1]};
        frame_done = s_q.running & rx_en & rise & (s_q.cnt == LAST);

        if (!rx_en)                         s_d.running = 1'b0;
        else if (!s_q.running && !flags_any) s_d.running = 1'b1;
        else if (s_q.running && err_any)     s_d.running = 1'b0;

        if (!s_q.running || !rx_en) begin
            s_d.cnt = '0;
        end else if (rise) begin
            s_d.sh  = frame_byte;
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: disabling reception drops the partial frame
    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (s_q.cnt == '0) && !s_q.running);
endmodule

// File: rtl/sync_rx_status.sv
module sync_rx_status
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              flags_any,
    output logic              err_any
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] seen;
    } stat_t;

    stat_t s_d, s_q;
    logic  rd_stat, wr_stat;

    always_comb begin
        s_d     = s_q;
        rd_stat = rd_en && (rd_addr == ADDR_STAT);
        wr_stat = wr_en && (wr_addr == ADDR_STAT);

        for (int i = 0; i < FLAG_N; i++) begin
            if (rd_stat && s_q.flags[i]) s_d.seen[i] = 1'b1;
            if (wr_stat && !wr_data[i] && s_q.seen[i]) begin
                s_d.flags[i] = 1'b0;
                s_d.seen[i]  = 1'b0;
            end
        end

        if (frame_done) begin
            if (s_q.flags[F_RDY]) begin
                s_d.flags[F_OVR] = 1'b1;
            end else begin
                s_d.data         = frame_byte;
                s_d.flags[F_RDY] = 1'b1;
            end
        end

        rd_data   = (rd_addr == ADDR_STAT) ? DATA_W'(s_q.flags) : s_q.data;
        err_any   = s_q.flags[F_OVR] | s_q.flags[F_FER] | s_q.flags[F_PER];
        flags_any = |s_q.flags;
        irq_rx    = s_q.flags[F_RDY] & irq_en;
        irq_err   = err_any & irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: while overrun is flagged the held byte never changes
    assert_ovr_holds_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flags[F_OVR] |=> s_q.data == $past(s_q.data));
    // R6, R7: ready falls only on a zero-write to the status address
    assert_rdy_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.flags[F_RDY]) |-> $past(wr_en && wr_addr == ADDR_STAT && !wr_data[F_RDY]));
    // R9: framing and parity flags stay low
    assert_no_frame_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.flags[F_FER] || s_q.flags[F_PER]));
endmodule

// File: rtl/sync_rx_channel.sv
module sync_rx_channel
    import sync_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              rise, bit_val, frame_done, flags_any, err_any;
    logic [DATA_W-1:0] frame_byte;

    sync_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .rise(rise), .bit_val(bit_val));

    sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flags_any(flags_any),
        .err_any(err_any), .rise(rise), .bit_val(bit_val),
        .frame_done(frame_done), .frame_byte(frame_byte));

    sync_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_byte(frame_byte),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_en(irq_en), .irq_rx(irq_rx), .irq_err(irq_err),
        .flags_any(flags_any), .err_any(err_any));

    // R4: interrupts are silent when masked
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !(irq_rx || irq_err));
    // R5: with an error flagged, no frame completes
    assert_halt_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_any) && err_any |-> !frame_done);
endmodule

// File: tb/test_sync_rx_channel.sv
module test_sync_rx_channel;
    logic       clk = 0, rst_n = 0, rx_en = 0, irq_en = 0;
    logic       ser_clk = 0, ser_dat = 0, rd_en = 0, wr_en = 0;
    logic [0:0] rd_addr = 0, wr_addr = 0;
    logic [7:0] wr_data = 0, rd_data, rv;
    logic       irq_rx, irq_err;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    localparam logic [7:0] VEC [6] = '{8'h01, 8'h80, 8'hA5, 8'h3C, 8'hFF, 8'h00};

    always #4 clk = ~clk;

    sync_rx_channel i_sync_rx_channel (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_en(irq_en),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_rx(irq_rx), .irq_err(irq_err));

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b; ticks(4);
        ser_clk = 1; ticks(4);
        ser_clk = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        ticks(6);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); rd_en = 1; rd_addr = a; #1 v = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic clear_all();
        logic [7:0] s;
        rd(1, s); wr(8'h00); ticks(3);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        ticks(3); rst_n = 1; ticks(1);
        rd(0, rv); check(rv, 8'h00, "R1 data after reset");
        rd(1, rv); check(rv, 8'h00, "R1 status after reset");
        check({6'b0, irq_rx, irq_err}, 8'h00, "R1 irqs after reset");
        rx_en = 1; irq_en = 1; ticks(3);

        // vector walk: R2 bytes, R4 irq, R7 data read keeps ready
        foreach (VEC[k]) begin
            send_byte(VEC[k]);
            check({7'b0, irq_rx}, 8'h01, "R4 irq_rx on ready");
            rd(0, rv); check(rv, VEC[k], "R2 received byte");
            rd(1, rv); check(rv, 8'h01, "R7 ready kept after data read");
            wr(8'h00); ticks(3);
            rd(1, rv); check(rv, 8'h00, "R6 ready cleared after read+write0");
        end

        // R6: write 0 without read is ignored; write 1 ignored
        send_byte(8'h5A);
        wr(8'h00); rd(1, rv); check(rv, 8'h01, "R6 write0 without read ignored");
        wr(8'hFF); rd(1, rv); check(rv, 8'h01, "R6 write1 ignored");
        wr(8'hFE); rd(1, rv); check(rv, 8'h00, "R6 write0 after read clears");
        ticks(3);

        // R4 masking
        send_byte(8'h11);
        irq_en = 0; ticks(1);
        check({6'b0, irq_rx, irq_err}, 8'h00, "R4 irqs masked");
        irq_en = 1;

        // R3 overrun
        send_byte(8'h22);
        rd(0, rv); check(rv, 8'h11, "R3 data kept on overrun");
        rd(1, rv); check(rv, 8'h03, "R3 ovr+ready set, R9 fer/per zero");
        check({6'b0, irq_rx, irq_err}, 8'h03, "R4 both irqs on overrun");

        // R5 lockout: clear only overrun, ready still set
        wr(8'hFD); ticks(3);
        rd(1, rv); check(rv, 8'h01, "R5 only overrun cleared");
        check({7'b0, irq_err}, 8'h00, "R4 irq_err drops after clear");
        send_byte(8'h33);
        rd(0, rv); check(rv, 8'h11, "R5 frame ignored while ready set");
        rd(1, rv); check(rv, 8'h01, "R5 no new overrun while halted");
        wr(8'hFE); ticks(3);
        send_byte(8'h44);
        rd(0, rv); check(rv, 8'h44, "R5 reception resumes after clear");
        rd(1, rv); check(rv, 8'h01, "R9 status only ready");

        // R10: toggle enable while ready set
        rx_en = 0; ticks(3); rx_en = 1; ticks(3);
        send_byte(8'h77);
        rd(0, rv); check(rv, 8'h44, "R10 no frame while ready after re-enable");
        rd(1, rv); check(rv, 8'h01, "R10 no overrun flagged");
        clear_all();

        // R8: partial frame discarded
        send_bit(1); send_bit(1); send_bit(1);
        rx_en = 0; ticks(4); rx_en = 1; ticks(3);
        send_byte(8'hA6);
        rd(0, rv); check(rv, 8'hA6, "R8 partial frame dropped");
        rd(1, rv); check(rv, 8'h01, "R8 single ready after re-enable");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule